// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A watchdog counter that counts down once per clock while it is enabled. When the count runs out, the block raises a one-cycle timeout pulse and starts again from the programmed timeout value. Software keeps the timer from expiring by writing an ordered pair of 16-bit service words to a service register. Each correct pair reloads the counter. A second ordered pair of words clears a soft-lock flag. While that flag is set, it freezes the control and timeout registers.

The block has a word-wide register write port with a combinational read path. Software can choose between two service modes. In fixed mode the service pair is constant. In keyed mode each expected word is computed from the service word written before it. The live count can be read back only while the timer is stopped. While the timer runs, the count register reads as zero.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control, timeout, service and count registers all read zero, and `timeout_o` is low.
- R2: Control bit 0 is the enable. A write that sets the enable loads the counter with the timeout value T. After that the counter decrements once per clock. On the clock edge where an enabled counter is at zero, the counter reloads T and `timeout_o` pulses high for exactly one cycle, so pulses repeat every T+1 cycles.
- R3: In fixed mode, writing 0xA602 and then 0xB480 to the service register reloads the counter with T on the second write.
- R4: A service write that is not the next expected word returns the detector to expecting the first word. Stray words, words in the wrong order, or a lone second word cause no reload.
- R5: Writing 0xC520 and then 0xD928 to the service register clears the soft-lock flag (control bit 1). An unlock pair that has another word between its two words has no effect.
- R6: The soft-lock flag is set only by a control write. While it is set, writes to the control and timeout registers are ignored, including a write that tries to clear the flag.
- R7: When control bit 2 (keyed mode) is set, each expected service word is (previous × 17 + 3) mod 65536, where "previous" is the last word written to the service register. Writing the fixed pair does not reload the counter in this mode.
- R8: Only the low 16 bits of a service write are compared. The service register always reads zero.
- R9: The count register reads the live counter while the timer is disabled and reads zero while it is enabled. Writes to the count register have no effect.
- R10: Register byte offsets are control 0x00, timeout 0x04, service 0x10 and count 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
A wrong sequence-detector state shows up as a missing reload or an extra reload. The count read back after stopping the timer is then off by the number of cycles since the service pair, and the error is visible one clock after the second word. A wrong counter or reload value moves the timeout pulse away from T+1 cycles after enabling, so it shows up within one period. A soft-lock flag that is set or cleared wrongly changes the control readback at once.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;

  // Register byte offsets
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_TOV  = 8'h04;
  localparam logic [7:0] OFF_SVC  = 8'h10;
  localparam logic [7:0] OFF_CNT  = 8'h14;

  // Control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_LOCK  = 1;
  localparam int CB_KEYED = 2;

  localparam logic [KEY_W-1:0] SVC_KEY_A = 16'hA602;
  localparam logic [KEY_W-1:0] SVC_KEY_B = 16'hB480;
  localparam logic [KEY_W-1:0] UNL_KEY_A = 16'hC520;
  localparam logic [KEY_W-1:0] UNL_KEY_B = 16'hD928;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SVC  = 2'd1,
    SEQ_UNL  = 2'd2
  } seq_st_e;

  // Next keyed service word: prev*17 + 3, wrapping at the key width
  function automatic logic [KEY_W-1:0] kwd_next_key(input logic [KEY_W-1:0] prev);
    logic [KEY_W-1:0] r;
    r = (prev << 4) + prev + KEY_W'(3);
    return r;
  endfunction
endpackage

// File: rtl/kwd_ctrl_regs.sv
module kwd_ctrl_regs
  import kwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              tov_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlock_ev,
  output logic              en_q,
  output logic              lock_q,
  output logic              keyed_q,
  output logic [CNT_W-1:0]  tov_q,
  output logic              start_ev
);
  logic ctrl_acc, tov_acc;

  // Writes are accepted only while the soft-lock flag is clear
  assign ctrl_acc = ctrl_we && !lock_q;
  assign tov_acc  = tov_we && !lock_q;
  assign start_ev = ctrl_acc && wdata[CB_EN] && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      lock_q  <= 1'b0;
      keyed_q <= 1'b0;
    end else if (ctrl_acc) begin
      en_q    <= wdata[CB_EN];
      lock_q  <= wdata[CB_LOCK];
      keyed_q <= wdata[CB_KEYED];
    end else if (unlock_ev) begin
      lock_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tov_q <= '0;
    else if (tov_acc) tov_q <= wdata[CNT_W-1:0];
  end
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_we,
  input  logic [KEY_W-1:0] word,
  input  logic             keyed,
  output logic             svc_ok,
  output logic             unlock_ev,
  output seq_st_e          st_q
);
  logic [KEY_W-1:0] last_q;
  logic [KEY_W-1:0] exp_key;
  seq_st_e          st_d;

  // Expected service word for the current stage
  always_comb begin
    if (keyed)                exp_key = kwd_next_key(last_q);
    else if (st_q == SEQ_SVC) exp_key = SVC_KEY_B;
    else                      exp_key = SVC_KEY_A;
  end

  assign svc_ok    = svc_we && (st_q == SEQ_SVC) && (word == exp_key);
  assign unlock_ev = svc_we && (st_q == SEQ_UNL) && (word == UNL_KEY_B);

  always_comb begin
    st_d = st_q;
    if (svc_we) begin
      if (st_q == SEQ_IDLE) begin
        if (word == exp_key)        st_d = SEQ_SVC;
        else if (word == UNL_KEY_A) st_d = SEQ_UNL;
        else                        st_d = SEQ_IDLE;
      end else begin
        st_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      last_q <= '0;
    end else begin
      st_q <= st_d;
      if (svc_we) last_q <= word;
    end
  end
endmodule

// File: rtl/kwd_downcnt.sv
module kwd_downcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] tov,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_ev,
  output logic             timeout_q
);
  assign wrap_ev = en && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      timeout_q <= wrap_ev;
      if (load || wrap_ev) cnt_q <= tov;
      else if (en)         cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              timeout_o
);
  logic sel_ctrl, sel_tov, sel_svc, sel_cnt;
  logic en_q, lock_q, keyed_q, start_ev;
  logic svc_ok, unlock_ev, load_ev, wrap_ev;
  logic [CNT_W-1:0] tov_q, cnt_q;
  seq_st_e seq_st;

  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign sel_tov  = (addr == ADDR_W'(OFF_TOV));
  assign sel_svc  = (addr == ADDR_W'(OFF_SVC));
  assign sel_cnt  = (addr == ADDR_W'(OFF_CNT));

  kwd_ctrl_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(wr_en && sel_ctrl), .tov_we(wr_en && sel_tov),
    .wdata(wdata), .unlock_ev(unlock_ev),
    .en_q(en_q), .lock_q(lock_q), .keyed_q(keyed_q),
    .tov_q(tov_q), .start_ev(start_ev)
  );

  kwd_keyseq u_seq (
    .clk(clk), .rst_n(rst_n),
    .svc_we(wr_en && sel_svc), .word(wdata[KEY_W-1:0]), .keyed(keyed_q),
    .svc_ok(svc_ok), .unlock_ev(unlock_ev), .st_q(seq_st)
  );

  assign load_ev = start_ev || svc_ok;

  kwd_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .load(load_ev), .tov(tov_q),
    .cnt_q(cnt_q), .wrap_ev(wrap_ev), .timeout_q(timeout_o)
  );

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[CB_EN]    = en_q;
      rdata[CB_LOCK]  = lock_q;
      rdata[CB_KEYED] = keyed_q;
    end else if (sel_tov) begin
      rdata[CNT_W-1:0] = tov_q;
    end else if (sel_cnt && !en_q) begin
      rdata[CNT_W-1:0] = cnt_q;
    end
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              timeout_o,
  input logic              en_q,
  input logic              lock_q,
  input logic              keyed_q,
  input logic [CNT_W-1:0]  tov_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              load_ev,
  input logic              svc_ok,
  input logic              unlock_ev
);
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q != '0 && !load_ev) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r2_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == '0 && !load_ev) |=> (timeout_o && cnt_q == $past(tov_q)));

  a_r2_pulse_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> $past(en_q && cnt_q == '0));

  a_r3_service_reload: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (cnt_q == $past(tov_q)));

  a_r5_unlock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_ev |=> !lock_q);

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !unlock_ev) |=> lock_q);

  a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(tov_q) && $stable(en_q) && $stable(keyed_q)));

  a_r8_svc_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(OFF_SVC)) |-> (rdata == '0));

  a_r9_count_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && addr == ADDR_W'(OFF_CNT)) |-> (rdata == '0));
endmodule

bind keyed_watchdog kwd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .timeout_o(timeout_o),
  .en_q(en_q), .lock_q(lock_q), .keyed_q(keyed_q), .tov_q(tov_q), .cnt_q(cnt_q),
  .load_ev(load_ev), .svc_ok(svc_ok), .unlock_ev(unlock_ev)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  localparam logic [4:0] A_CTRL = 5'h00, A_TOV = 5'h04, A_SVC = 5'h10, A_CNT = 5'h14;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        timeout_o;

  keyed_watchdog dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                      .wdata(wdata), .rdata(rdata), .timeout_o(timeout_o));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Bench model
  int          T = 0;
  logic [31:0] m_cnt = '0;
  bit          m_en = 1'b0, m_keyed = 1'b0;
  int          m_st = 0;
  logic [15:0] m_last = '0;

  function automatic logic [15:0] nk(input logic [15:0] p);
    int v;
    v = (int'(p) * 17 + 3) % 65536;
    return v[15:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a negedge; one clock edge; returns at the next negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic m_tick(input bit ld);
    if (ld) m_cnt = 32'(T);
    else if (m_en) m_cnt = (m_cnt == 0) ? 32'(T) : m_cnt - 1;
  endtask

  task automatic ctl(input logic [2:0] v);
    bit rise;
    rise = v[0] && !m_en;
    wr(A_CTRL, {29'd0, v});
    m_tick(rise);
    m_en = v[0]; m_keyed = v[2];
  endtask

  task automatic svc(input logic [31:0] w);
    logic [15:0] k, e;
    bit rl;
    k = w[15:0];
    e = m_keyed ? nk(m_last) : ((m_st == 1) ? 16'hB480 : 16'hA602);
    rl = (m_st == 1) && (k == e);
    if (m_st == 0) m_st = (k == e) ? 1 : ((k == 16'hC520) ? 2 : 0);
    else m_st = 0;
    m_last = k;
    wr(A_SVC, w);
    m_tick(rl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 offsets
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_TOV, v);  chk("R1 tov", v, 0);
    rd(A_SVC, v);  chk("R1 svc", v, 0);
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    chk("R1 timeout", {31'd0, timeout_o}, 0);

    wr(A_TOV, 32'h0000_0005);
    rd(A_TOV, v); chk("R10 tov readback", v, 5);
    wr(A_CNT, 32'h0000_0055);
    rd(A_CNT, v); chk("R9 count write ignored", v, 0);

    // R2 period sweep
    for (int t = 1; t <= 10; t++) begin
      int first, second, npulse;
      first = -1; second = -1; npulse = 0;
      T = t;
      wr(A_TOV, 32'(t));
      ctl(3'b001);
      for (int i = 0; i <= 3 * t + 3; i++) begin
        if (timeout_o) begin
          npulse++;
          if (first < 0) first = i; else if (second < 0) second = i;
        end
        @(negedge clk);
      end
      chk("R2 first pulse", 32'(first), 32'(t + 1));
      chk("R2 second pulse", 32'(second), 32'(2 * t + 2));
      chk("R2 pulse count", 32'(npulse), 3);
      ctl(3'b000);
    end

    // R9 visible when disabled, zero when enabled
    T = 20; wr(A_TOV, 32'd20);
    ctl(3'b001);
    rd(A_CNT, v); chk("R9 hidden while enabled", v, 0);
    for (int i = 0; i < 5; i++) begin @(negedge clk); m_tick(1'b0); end
    ctl(3'b000);
    rd(A_CNT, v); chk("R9 frozen count", v, m_cnt);
    chk("R9 frozen count value", m_cnt, 14);

    // R3 fixed service
    ctl(3'b001);
    @(negedge clk); m_tick(1'b0);
    svc(32'h0000_A602); svc(32'h0000_B480);
    ctl(3'b000);
    rd(A_CNT, v); chk("R3 service reload", v, m_cnt);
    chk("R3 model value", m_cnt, 19);

    // R4 broken sequences
    ctl(3'b001);
    svc(32'hA602); svc(32'h1234); svc(32'hB480);
    svc(32'hB480); svc(32'hA602); svc(32'hA602); svc(32'hB480);
    ctl(3'b000);
    rd(A_CNT, v); chk("R4 no reload", v, m_cnt);
    chk("R4 model value", m_cnt, 12);

    // R8 upper bits ignored, service reads zero
    ctl(3'b001);
    svc(32'hFFFF_A602); svc(32'h1234_B480);
    rd(A_SVC, v); chk("R8 svc reads zero", v, 0);
    ctl(3'b000);
    rd(A_CNT, v); chk("R8 masked service reload", v, 19);

    // R5 / R6 soft lock
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, v); chk("R6 lock set", v, 2);
    wr(A_TOV, 32'd99);
    rd(A_TOV, v); chk("R6 tov frozen", v, 20);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v); chk("R6 ctrl frozen", v, 2);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R6 lock not cleared by write", v, 2);
    svc(32'hC520); svc(32'h1111); svc(32'hD928);
    rd(A_CTRL, v); chk("R5 broken unlock", v, 2);
    svc(32'hC520); svc(32'hD928);
    rd(A_CTRL, v); chk("R5 unlocked", v, 0);
    wr(A_TOV, 32'd20);
    rd(A_TOV, v); chk("R6 tov writable after unlock", v, 20);

    // R7 keyed service sweep
    for (int k = 0; k < 6; k++) begin
      ctl(3'b101);
      svc({16'h0, nk(m_last)}); svc({16'h0, nk(m_last)});
      ctl(3'b100);
      rd(A_CNT, v); chk("R7 keyed reload", v, m_cnt);
      chk("R7 keyed model", m_cnt, 19);
    end
    ctl(3'b101);
    svc(32'hA602); svc(32'hB480);
    ctl(3'b100);
    rd(A_CNT, v); chk("R7 fixed pair rejected", v, m_cnt);
    chk("R7 fixed pair model", m_cnt, 17);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule